// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block is a multi-cycle controller that moves 16-bit words between a processor's register file and a byte-wide memory through a 16-bit stack pointer that it owns. A single-cycle start pulse together with an operation code launches one operation. Operand inputs are captured in the acceptance cycle and may change freely afterwards. Supported operations are a plain push and a flag-word push, a plain pop and a flag-word pop, a call (taken or not taken), an unconditional return, a conditional return, a return from interrupt, a restart to a fixed vector, and a store of the stack pointer to an absolute address.

The surrounding core fetches the instruction and evaluates any branch condition. It then presents the address of the next instruction on `pc_in` and the outcome of the condition on `cond_ok`. The sequencer drives the memory bus, which assumes a combinational read. When the operation finishes it reports the popped word, or a new program counter with a load strobe. A single `done` pulse marks the last cycle.

Cycle counts are measured from the acceptance edge. Cycle 1 is the cycle after the edge where `start` was sampled, and `done` is high in cycle N of an N-cycle operation. Operation codes: 0 push, 1 pop, 2 flag pop, 3 call, 4 return, 5 conditional return, 6 return from interrupt, 7 restart, 8 store stack pointer, 9 flag push. Codes 10 to 15 are undefined.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 0xFFFE and `busy`, `done`, `mem_we`, `pc_load` and `ime_set` are all 0.
- R2: Push (code 0) takes 4 cycles. It writes `data_in[15:8]` at address sp-1 and then `data_in[7:0]` at address sp-2, and leaves `sp` reduced by 2.
- R3: Flag push (code 9) behaves like push, except the lower byte written is `{data_in[7:4],4'b0000}`: zero in bit 7, subtract in bit 6, half-carry in bit 5, carry in bit 4, and bits 3..0 zero.
- R4: Pop (code 1) takes 3 cycles and performs no writes. It reads the low byte at sp and the high byte at sp+1, presents `{high,low}` on `pop_data` in the done cycle, and leaves `sp` increased by 2.
- R5: Flag pop (code 2) behaves like pop, except bits 3..0 of `pop_data` are forced to 0.
- R6: Call (code 3) with `cond_ok`=1 takes 6 cycles. It pushes `pc_in` (high byte at sp-1, low byte at sp-2) and, in the done cycle, asserts `pc_load` with `pc_new` = `data_in`. With `cond_ok`=0 it takes 3 cycles, with no write, no `pc_load` and `sp` unchanged.
- R7: Return (code 4) takes 4 cycles, ignores `cond_ok`, pops a word as in R4 and asserts `pc_load` with that word on `pc_new`. Conditional return (code 5) does the same in 5 cycles when `cond_ok`=1. When `cond_ok`=0 it takes 2 cycles with no load and `sp` unchanged.
- R8: Return from interrupt (code 6) behaves as R7's return and, in its done cycle, also pulses `ime_set` for one cycle. No other operation asserts `ime_set`.
- R9: Restart (code 7) takes 4 cycles, pushes `pc_in` as in R6, and loads `pc_new` = `data_in[2:0]`*8.
- R10: Store stack pointer (code 8) takes 5 cycles. It writes `sp[7:0]` at address `data_in` and `sp[15:8]` at address `data_in`+1, and leaves `sp` unchanged.
- R11: The stack pointer wraps modulo 2^16 on both increment and decrement, and changes by exactly one per cycle when it changes.
- R12: `done` is a one-cycle pulse. `busy` stays high from acceptance through the done cycle. A start while busy is ignored, and a start with an undefined code (10 to 15) is ignored with no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled when idle |
| op | input | 4 | Operation code |
| data_in | input | 16 | Push word, call target, store address or restart vector |
| pc_in | input | 16 | Return address pushed by call and restart |
| cond_ok | input | 1 | Branch condition outcome for call and conditional return |
| mem_addr | output | 16 | Byte memory address |
| mem_wdata | output | 8 | Byte memory write data |
| mem_we | output | 1 | Byte memory write enable |
| mem_rdata | input | 8 | Byte memory read data, combinational with mem_addr |
| sp | output | 16 | Stack pointer |
| pop_data | output | 16 | Most recently popped word |
| pc_new | output | 16 | Program counter value to load |
| pc_load | output | 1 | Load strobe for pc_new |
| ime_set | output | 1 | Interrupt master enable set pulse |
| done | output | 1 | Final-cycle pulse |
| busy | output | 1 | Operation in progress |

## Verification
Random operation streams mix all ten codes and the undefined ones with random operands and conditions. The word that pops back then depends on every earlier push, store and wrap, so any error in byte order or address offset shows up in later pops. Taken and not-taken variants of call and conditional return are both drawn, which separates the two cycle counts and shows whether a write or a load leaks into the untaken path. Directed cases pop across 0xFFFF into 0x0000 and push back across the boundary. They also raise a second start in the middle of a push and issue undefined codes, which tells a correctly ignored request apart from one that was partly executed. Operands are scrambled after acceptance, which reveals any operand that was not captured at the start.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STEP_W = 3;

    typedef enum logic [3:0] {
        OP_PUSH  = 4'd0,
        OP_POP   = 4'd1,
        OP_POPF  = 4'd2,
        OP_CALL  = 4'd3,
        OP_RET   = 4'd4,
        OP_RETC  = 4'd5,
        OP_RETI  = 4'd6,
        OP_RST   = 4'd7,
        OP_STSP  = 4'd8,
        OP_PUSHF = 4'd9
    } stk_op_e;

    // Step numbers are 1-based; zero means the phase is unused.
    typedef struct packed {
        logic              valid;
        logic [STEP_W-1:0] len;
        logic [STEP_W-1:0] push_at;
        logic [STEP_W-1:0] pop_at;
        logic [STEP_W-1:0] st_at;
        logic              push_pc;
        logic              load_pc;
        logic              ime;
        logic              flags;
    } stk_plan_t;

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
    import stk_pkg::*;
(
    input  logic [3:0] op,
    input  logic       cond_ok,
    output stk_plan_t  plan
);

    always_comb begin
        plan       = '0;
        plan.valid = 1'b1;
        case (op)
            OP_PUSH, OP_PUSHF: begin
                plan.len     = 3'd4;
                plan.push_at = 3'd2;
                plan.flags   = (op == OP_PUSHF);
            end
            OP_POP, OP_POPF: begin
                plan.len    = 3'd3;
                plan.pop_at = 3'd1;
                plan.flags  = (op == OP_POPF);
            end
            OP_CALL: begin
                if (cond_ok) begin
                    plan.len     = 3'd6;
                    plan.push_at = 3'd3;
                    plan.push_pc = 1'b1;
                    plan.load_pc = 1'b1;
                end else begin
                    plan.len = 3'd3;
                end
            end
            OP_RET, OP_RETI: begin
                plan.len     = 3'd4;
                plan.pop_at  = 3'd1;
                plan.load_pc = 1'b1;
                plan.ime     = (op == OP_RETI);
            end
            OP_RETC: begin
                if (cond_ok) begin
                    plan.len     = 3'd5;
                    plan.pop_at  = 3'd2;
                    plan.load_pc = 1'b1;
                end else begin
                    plan.len = 3'd2;
                end
            end
            OP_RST: begin
                plan.len     = 3'd4;
                plan.push_at = 3'd2;
                plan.push_pc = 1'b1;
                plan.load_pc = 1'b1;
            end
            OP_STSP: begin
                plan.len   = 3'd5;
                plan.st_at = 3'd3;
            end
            default: plan.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_flag_fmt.sv
module stk_flag_fmt #(
    parameter int BYTE_W = 8,
    parameter int KEEP   = 4
) (
    input  logic [BYTE_W-1:0] raw,
    input  logic              en,
    output logic [BYTE_W-1:0] fmt
);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        if (i >= BYTE_W - KEEP) begin : g_keep
            assign fmt[i] = raw[i];
        end else begin : g_mask
            assign fmt[i] = raw[i] & ~en;
        end
    end

endmodule

// File: rtl/stk_sp_adj.sv
module stk_sp_adj #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] nxt
);

    always_comb begin
        if (inc)      nxt = cur + W'(1);
        else if (dec) nxt = cur - W'(1);
        else          nxt = cur;
    end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stk_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] SP_RESET  = 16'hFFFE,
    parameter int           VEC_W     = 3,
    parameter int           VEC_SHIFT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   op,
    input  logic [W-1:0] data_in,
    input  logic [W-1:0] pc_in,
    input  logic         cond_ok,
    output logic [W-1:0] mem_addr,
    output logic [W/2-1:0] mem_wdata,
    output logic         mem_we,
    input  logic [W/2-1:0] mem_rdata,
    output logic [W-1:0] sp,
    output logic [W-1:0] pop_data,
    output logic [W-1:0] pc_new,
    output logic         pc_load,
    output logic         ime_set,
    output logic         done,
    output logic         busy
);

    localparam int B     = W / 2;
    localparam int VEC_Z = W - VEC_W - VEC_SHIFT;

    typedef struct packed {
        logic              busy;
        stk_plan_t         plan;
        logic [STEP_W-1:0] step;
        logic [W-1:0]      sp;
        logic [W-1:0]      word;
        logic [W-1:0]      target;
        logic [W-1:0]      popped;
    } seq_t;

    seq_t q, d;

    stk_plan_t    plan_in;
    logic [W-1:0] sp_nxt;
    logic [B-1:0] push_lo, pop_lo;
    logic         ph_dec, ph_inc, ph_wr_hi, ph_wr_lo;
    logic         ph_rd_lo, ph_rd_hi, ph_st_lo, ph_st_hi, ph_last;

    stk_op_decode u_dec (
        .op      (op),
        .cond_ok (cond_ok),
        .plan    (plan_in)
    );

    stk_sp_adj #(.W(W)) u_sp (
        .cur (q.sp),
        .inc (ph_inc),
        .dec (ph_dec),
        .nxt (sp_nxt)
    );

    stk_flag_fmt #(.BYTE_W(B)) u_fmt_push (
        .raw (q.word[B-1:0]),
        .en  (q.plan.flags),
        .fmt (push_lo)
    );

    stk_flag_fmt #(.BYTE_W(B)) u_fmt_pop (
        .raw (mem_rdata),
        .en  (q.plan.flags),
        .fmt (pop_lo)
    );

    // Phase flags: which action falls on the current step.
    always_comb begin
        ph_dec   = 1'b0;
        ph_inc   = 1'b0;
        ph_wr_hi = 1'b0;
        ph_wr_lo = 1'b0;
        ph_rd_lo = 1'b0;
        ph_rd_hi = 1'b0;
        ph_st_lo = 1'b0;
        ph_st_hi = 1'b0;
        ph_last  = 1'b0;
        if (q.busy) begin
            ph_last = (q.step == q.plan.len);
            if (q.plan.push_at != '0) begin
                ph_wr_hi = (q.step == q.plan.push_at);
                ph_wr_lo = (q.step == q.plan.push_at + STEP_W'(1));
                ph_dec   = (q.step == q.plan.push_at - STEP_W'(1)) || ph_wr_hi;
            end
            if (q.plan.pop_at != '0) begin
                ph_rd_lo = (q.step == q.plan.pop_at);
                ph_rd_hi = (q.step == q.plan.pop_at + STEP_W'(1));
                ph_inc   = ph_rd_lo || ph_rd_hi;
            end
            if (q.plan.st_at != '0) begin
                ph_st_lo = (q.step == q.plan.st_at);
                ph_st_hi = (q.step == q.plan.st_at + STEP_W'(1));
            end
        end
    end

    always_comb begin
        d         = q;
        d.sp      = sp_nxt;
        mem_addr  = q.sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        if (!q.busy) begin
            if (start && plan_in.valid) begin
                d.busy = 1'b1;
                d.plan = plan_in;
                d.step = STEP_W'(1);
                d.word = plan_in.push_pc ? pc_in : data_in;
                if (op == OP_RST)
                    d.target = {{VEC_Z{1'b0}}, data_in[VEC_W-1:0], {VEC_SHIFT{1'b0}}};
                else
                    d.target = data_in;
            end
        end else begin
            if (ph_wr_hi) begin
                mem_we    = 1'b1;
                mem_wdata = q.word[W-1:B];
            end
            if (ph_wr_lo) begin
                mem_we    = 1'b1;
                mem_wdata = push_lo;
            end
            if (ph_rd_lo) d.popped[B-1:0] = pop_lo;
            if (ph_rd_hi) d.popped[W-1:B] = mem_rdata;
            if (ph_st_lo) begin
                mem_addr  = q.target;
                mem_we    = 1'b1;
                mem_wdata = q.sp[B-1:0];
            end
            if (ph_st_hi) begin
                mem_addr  = q.target + W'(1);
                mem_we    = 1'b1;
                mem_wdata = q.sp[W-1:B];
            end
            if (ph_last) d.busy = 1'b0;
            else         d.step = q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.sp <= SP_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign sp       = q.sp;
    assign pop_data = q.popped;
    assign done     = ph_last;
    assign pc_load  = ph_last & q.plan.load_pc;
    assign ime_set  = ph_last & q.plan.ime;
    assign pc_new   = (q.plan.pop_at != '0) ? q.popped : q.target;

endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [3:0]   op,
    input logic         busy,
    input logic         done,
    input logic         mem_we,
    input logic         pc_load,
    input logic         ime_set,
    input logic [W-1:0] sp
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R12

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);  // R12

    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op > 4'd9) |=> !busy);  // R12

    AST_SP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> ((sp == $past(sp) + W'(1)) || (sp == $past(sp) - W'(1))));  // R11

    AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);  // R6

    AST_IME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ime_set |-> (done && pc_load));  // R8

    AST_WRITE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !done));  // R2

endmodule

bind stack_seq stk_checker #(.W(W)) u_stk_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .busy    (busy),
    .done    (done),
    .mem_we  (mem_we),
    .pc_load (pc_load),
    .ime_set (ime_set),
    .sp      (sp)
);

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] data_in = '0;
    logic [15:0] pc_in = '0;
    logic        cond_ok = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] sp;
    logic [15:0] pop_data;
    logic [15:0] pc_new;
    logic        pc_load;
    logic        ime_set;
    logic        done;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [15:0] m_sp;

    logic [7:0] mem [0:4095];

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    stack_seq i_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .data_in(data_in),
        .pc_in(pc_in), .cond_ok(cond_ok), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .sp(sp), .pop_data(pop_data), .pc_new(pc_new), .pc_load(pc_load),
        .ime_set(ime_set), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R2";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4, 4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            4'd8: return "R10";
            4'd9: return "R3";
            default: return "R12";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] o, input logic [15:0] d,
                          input logic [15:0] pc, input bit c, input bit poke,
                          input string tag);
        int          e_len = 0;
        int          e_nw = 0;
        logic [15:0] e_wa [2];
        logic [7:0]  e_wd [2];
        logic [15:0] e_sp = m_sp;
        bit          e_load = 0;
        logic [15:0] e_pc = '0;
        bit          e_ime = 0;
        bit          e_pop = 0;
        logic [15:0] pw = '0;
        logic [15:0] a1 = m_sp + 16'd1;
        logic [15:0] a2;
        int          nw = 0;
        logic [15:0] g_wa [2];
        logic [7:0]  g_wd [2];
        int          cnt = 0;
        bit          g_load = 0;
        bit          g_ime = 0;
        logic [15:0] g_pc = '0;
        logic [15:0] g_sp = '0;
        bit          do_push = 0;
        bit          do_pop = 0;
        bit          lo_mask = 0;

        case (o)
            4'd0, 4'd9: begin e_len = 4; do_push = 1; pw = d; lo_mask = (o == 4'd9); end
            4'd1, 4'd2: begin e_len = 3; do_pop = 1; e_pop = 1; lo_mask = (o == 4'd2); end
            4'd3: if (c) begin e_len = 6; do_push = 1; pw = pc; e_load = 1; e_pc = d; end
                  else e_len = 3;
            4'd4, 4'd6: begin e_len = 4; do_pop = 1; e_load = 1; e_ime = (o == 4'd6); end
            4'd5: if (c) begin e_len = 5; do_pop = 1; e_load = 1; end
                  else e_len = 2;
            4'd7: begin e_len = 4; do_push = 1; pw = pc; e_load = 1;
                        e_pc = {10'd0, d[2:0], 3'b000}; end
            4'd8: begin e_len = 5; e_nw = 2; a2 = d + 16'd1;
                        e_wa[0] = d; e_wd[0] = m_sp[7:0];
                        e_wa[1] = a2; e_wd[1] = m_sp[15:8]; end
            default: e_len = 0;
        endcase
        if (do_push) begin
            e_nw = 2;
            e_wa[0] = m_sp - 16'd1; e_wd[0] = pw[15:8];
            e_wa[1] = m_sp - 16'd2; e_wd[1] = lo_mask ? {pw[7:4], 4'b0} : pw[7:0];
            e_sp = m_sp - 16'd2;
        end
        if (do_pop) begin
            e_pc = {mem[a1[11:0]], mem[m_sp[11:0]]};
            if (lo_mask) e_pc[3:0] = 4'b0;
            e_sp = m_sp + 16'd2;
        end

        @(negedge clk);
        op = o; data_in = d; pc_in = pc; cond_ok = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        if (e_len == 0) begin
            for (int k = 0; k < 6; k++) begin
                chk(!busy && !done && !mem_we, tag, "undefined code activity",
                    {busy, done, mem_we}, 0);
                @(negedge clk);
            end
            chk(sp == m_sp, tag, "undefined code sp", sp, m_sp);
            return;
        end
        forever begin
            if (mem_we) begin
                if (nw < 2) begin g_wa[nw] = mem_addr; g_wd[nw] = mem_wdata; end
                nw++;
            end
            if (done || cnt > 12) begin
                g_load = pc_load; g_ime = ime_set; g_pc = pc_new; g_sp = sp;
                break;
            end
            data_in = 16'($urandom); pc_in = 16'($urandom); cond_ok = 1'($urandom);
            if (poke && cnt == 1) begin start = 1'b1; op = 4'd1; end
            else start = 1'b0;
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == e_len, tag, "cycle count", cnt, e_len);
        chk(nw == e_nw, tag, "write count", nw, e_nw);
        for (int k = 0; k < e_nw && k < nw; k++) begin
            chk(g_wa[k] == e_wa[k], tag, "write address", g_wa[k], e_wa[k]);
            chk(g_wd[k] == e_wd[k], tag, "write data", g_wd[k], e_wd[k]);
        end
        chk(g_sp == e_sp, tag, "stack pointer", g_sp, e_sp);
        chk(g_load == e_load, tag, "pc_load", g_load, e_load);
        if (e_load) chk(g_pc == e_pc, tag, "pc_new", g_pc, e_pc);
        chk(g_ime == e_ime, (o == 4'd6) ? "R8" : tag, "ime_set", g_ime, e_ime);
        if (e_pop) chk(pop_data == e_pc, tag, "pop_data", pop_data, e_pc);
        m_sp = e_sp;
        @(negedge clk);
        chk(!busy && !done, "R12", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R12 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 4096; k++) mem[k] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sp == 16'hFFFE, "R1", "reset sp", sp, 16'hFFFE);
        chk(!busy, "R1", "reset busy", busy, 0);
        chk(!done && !mem_we, "R1", "reset done/we", {done, mem_we}, 0);
        chk(!pc_load && !ime_set, "R1", "reset load/ime", {pc_load, ime_set}, 0);
        rst_n = 1'b1;
        m_sp = 16'hFFFE;

        // R11: pop across the top, then push back across zero
        run_op(4'd1, 16'h0, 16'h0, 1'b0, 1'b0, "R11");
        chk(sp == 16'h0000, "R11", "sp after wrap pop", sp, 0);
        run_op(4'd0, 16'hA55A, 16'h0, 1'b0, 1'b0, "R11");
        chk(sp == 16'hFFFE, "R11", "sp after wrap push", sp, 16'hFFFE);
        // R3/R5: flag byte packing and masking round trip
        run_op(4'd9, 16'h12FF, 16'h0, 1'b0, 1'b0, "R3");
        run_op(4'd2, 16'h0, 16'h0, 1'b0, 1'b0, "R5");
        chk(pop_data == 16'h12F0, "R5", "flag pop value", pop_data, 16'h12F0);
        // R6/R7/R8/R9 directed call/return pairs
        run_op(4'd3, 16'h4000, 16'h1234, 1'b1, 1'b0, "R6");
        run_op(4'd3, 16'h4000, 16'h1234, 1'b0, 1'b0, "R6");
        run_op(4'd5, 16'h0, 16'h0, 1'b0, 1'b0, "R7");
        run_op(4'd5, 16'h0, 16'h0, 1'b1, 1'b0, "R7");
        run_op(4'd7, 16'h0007, 16'hBEEF, 1'b0, 1'b0, "R9");
        run_op(4'd6, 16'h0, 16'h0, 1'b0, 1'b0, "R8");
        run_op(4'd4, 16'h0, 16'h0, 1'b0, 1'b0, "R7");
        // R10: store sp
        run_op(4'd8, 16'h0123, 16'h0, 1'b0, 1'b0, "R10");
        // R12: start while busy, undefined codes
        run_op(4'd0, 16'h7788, 16'h0, 1'b0, 1'b1, "R12");
        run_op(4'hA, 16'h0, 16'h0, 1'b0, 1'b0, "R12");
        run_op(4'hF, 16'h0, 16'h0, 1'b1, 1'b0, "R12");

        for (int n = 0; n < 400; n++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 10));
            run_op(o, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom_range(0, 7) == 0),
                   tag_of(o));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule